// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous memory array on each clock. A base address is captured on the rising edge whenever either of two address strobes is high: one strobe belongs to the processor and the other to a cache or memory controller. The upper address bits come straight from the captured base. The lowest two bits walk through a four-beat burst, and they step forward only in cycles where the advance input is high.

A static order input selects one of two burst orders. With it high, the low bits count upward from the captured value and wrap modulo four. With it low, they are the captured value XOR the beat number, which gives the interleaved order. Low is the default tie-off. Bursts are optional: a new address may be captured on every cycle with no dead cycle between loads. A one-bit output records which strobe made the most recent load.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held, `mem_addr` is all zeros and `src_ctl` is 0.
- R2: A rising edge with `strobe_cpu` or `strobe_ctl` high captures `addr_in`, and `mem_addr` equals that value from that edge onward until the next change.
- R3: When both strobes are high on the same edge, the processor strobe wins and `src_ctl` becomes 0. A load by `strobe_ctl` alone sets `src_ctl` to 1. `src_ctl` holds its value in cycles with no load.
- R4: `advance` has no effect on an edge that loads. The burst restarts at beat 0, so the low bits equal the loaded low bits.
- R5: With `order_lin` = 1, the low two bits equal (loaded low bits + beat) mod 4. For example, a base of 1 gives 1, 2, 3, 0.
- R6: With `order_lin` = 0 (the default tie-off), the low two bits equal the loaded low bits XOR beat. For example, a base of 1 gives 1, 0, 3, 2.
- R7: On an edge with no strobe and `advance` low, `mem_addr` keeps its value.
- R8: After the fourth beat, a further advance wraps the low bits back to the loaded base value.
- R9: Bits above bit 1 of `mem_addr` keep the loaded base throughout a burst. No carry passes out of the low two bits.
- R10: Loads on consecutive edges each take effect on their own edge, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address to capture |
| strobe_cpu | input | 1 | Processor address strobe (higher priority) |
| strobe_ctl | input | 1 | Controller address strobe |
| advance | input | 1 | Step the burst by one beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| mem_addr | output | ADDR_W | Address presented to the array |
| src_ctl | output | 1 | 1 if the last load came from the controller strobe |

## Verification
The step and hold properties assume that `order_lin` is a static strap: they are only evaluated in cycles where it has not moved. The input-driven properties also assume that the strobes and `advance` are never unknown after reset. The stimulus drives every input to a known value from time zero. In the random phase it changes the order input only in a cycle that also loads, so a burst never runs under two orders. Random strobe and advance densities are chosen so that bursts run long enough to wrap, and so that simultaneous strobes and load-with-advance cases occur often.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_CTL = 1'b1
    } src_e;

    typedef struct packed {
        beat_t beat;
    } ctr_state_t;

    function automatic beat_t step_linear(beat_t base, beat_t beat);
        return beat_t'(base + beat);
    endfunction
endpackage

// File: rtl/burst_load_arb.sv
module burst_load_arb
    import burst_pkg::*;
(
    input  logic strobe_cpu,
    input  logic strobe_ctl,
    output logic load,
    output src_e src
);
    always_comb begin
        load = strobe_cpu | strobe_ctl;
        // processor strobe has priority when both are high
        src  = strobe_cpu ? SRC_CPU : SRC_CTL;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  logic  advance,
    output beat_t beat_q
);
    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.beat = '0;
        end else if (advance) begin
            st_d.beat = beat_t'(st_q.beat + beat_t'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_q = st_q.beat;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  beat_t base_low,
    input  beat_t beat,
    input  logic  order_lin,
    output beat_t low_out
);
    beat_t inter_low;
    beat_t lin_low;

    genvar i;
    generate
        for (i = 0; i < BEAT_W; i++) begin : g_xor
            assign inter_low[i] = base_low[i] ^ beat[i];
        end
    endgenerate

    always_comb begin
        lin_low = step_linear(base_low, beat);
        low_out = order_lin ? lin_low : inter_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              advance,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              src_ctl
);
    localparam int UP_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        src_e              src;
    } base_state_t;

    base_state_t bs_d, bs_q;
    logic        load;
    src_e        load_src;
    beat_t       beat_q;
    beat_t       low_bits;

    burst_load_arb u_arb (
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .load       (load),
        .src        (load_src)
    );

    burst_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .beat_q  (beat_q)
    );

    always_comb begin
        bs_d = bs_q;
        if (load) begin
            bs_d.base = addr_in;
            bs_d.src  = load_src;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bs_q <= '{base: '0, src: SRC_CPU};
        end else begin
            bs_q <= bs_d;
        end
    end

    burst_order_map u_map (
        .base_low  (bs_q.base[BEAT_W-1:0]),
        .beat      (beat_q),
        .order_lin (order_lin),
        .low_out   (low_bits)
    );

    logic [UP_W-1:0] upper_bits;
    assign upper_bits = bs_q.base[ADDR_W-1:BEAT_W];
    assign mem_addr   = {upper_bits, low_bits};
    assign src_ctl    = (bs_q.src == SRC_CTL);
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_cpu,
    input logic              strobe_ctl,
    input logic              advance,
    input logic              order_lin,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              src_ctl
);
    logic any_ld;
    assign any_ld = strobe_cpu | strobe_ctl;

    // R2 and R4: a load shows the captured address whatever advance does
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_ld |=> mem_addr == $past(addr_in));

    assert_cpu_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_cpu |=> !src_ctl);

    assert_ctl_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ctl && !strobe_cpu) |=> src_ctl);

    assert_src_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ld |=> $stable(src_ctl));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ld && !advance) |=> (!$stable(order_lin) || $stable(mem_addr)));

    assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ld |=> $stable(mem_addr[ADDR_W-1:2]));

    assert_lin_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ld && advance && order_lin) |=>
            (!$stable(order_lin) || mem_addr[1:0] == 2'($past(mem_addr[1:0]) + 2'd1)));

    assert_inter_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ld && advance && !order_lin) |=>
            (!$stable(order_lin) || mem_addr[1:0] != $past(mem_addr[1:0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .order_lin  (order_lin),
    .mem_addr   (mem_addr),
    .src_ctl    (src_ctl)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
    localparam int AW = 18;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_cpu = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          advance = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          src_ctl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_src  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .advance(advance), .order_lin(order_lin),
        .mem_addr(mem_addr), .src_ctl(src_ctl)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_lin ? 2'(m_base[1:0] + m_beat) : (m_base[1:0] ^ m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at negedge, update model at posedge, return at next negedge
    task automatic step(input logic cpu, input logic ctl, input logic adv,
                        input logic ord, input logic [AW-1:0] a);
        strobe_cpu = cpu; strobe_ctl = ctl; advance = adv; order_lin = ord; addr_in = a;
        @(posedge clk);
        if (cpu || ctl) begin
            m_base = a; m_beat = '0; m_src = cpu ? 1'b0 : 1'b1;
        end else if (adv) begin
            m_beat = 2'(m_beat + 2'd1);
        end
        @(negedge clk);
    endtask

    task automatic burst_low(input string tag, input logic ord, input logic [AW-1:0] base,
                             input logic [1:0] s1, input logic [1:0] s2, input logic [1:0] s3);
        step(1'b1, 1'b0, 1'b0, ord, base);
        check(tag, 32'(mem_addr[1:0]), 32'(base[1:0]));
        step(1'b0, 1'b0, 1'b1, ord, '0);
        check(tag, 32'(mem_addr[1:0]), 32'(s1));
        step(1'b0, 1'b0, 1'b1, ord, '0);
        check(tag, 32'(mem_addr[1:0]), 32'(s2));
        step(1'b0, 1'b0, 1'b1, ord, '0);
        check(tag, 32'(mem_addr[1:0]), 32'(s3));
        step(1'b0, 1'b0, 1'b1, ord, '0);
        check("R8 wrap", 32'(mem_addr), 32'(base));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 addr", 32'(mem_addr), 32'd0);
        check("R1 src", 32'(src_ctl), 32'd0);
        rst_n = 1'b1;

        // R6 interleaved from base low 1: 1,0,3,2 then wrap
        burst_low("R6", 1'b0, 18'h2AB45, 2'd0, 2'd3, 2'd2);
        // R5 linear from base low 1: 1,2,3,0 then wrap
        burst_low("R5", 1'b1, 18'h13571, 2'd2, 2'd3, 2'd0);

        // R7 hold without advance
        step(1'b0, 1'b1, 1'b0, 1'b1, 18'h00F02);
        step(1'b0, 1'b0, 1'b1, 1'b1, '0);
        step(1'b0, 1'b0, 1'b0, 1'b1, '0);
        check("R7 hold", 32'(mem_addr), 32'h00F03);
        step(1'b0, 1'b0, 1'b0, 1'b1, '0);
        check("R7 hold", 32'(mem_addr), 32'h00F03);

        // R9 no carry into upper bits
        step(1'b1, 1'b0, 1'b0, 1'b1, 18'h3FFF3);
        step(1'b0, 1'b0, 1'b1, 1'b1, '0);
        check("R9 upper", 32'(mem_addr), 32'h3FFF0);

        // R3 priority and source tracking
        step(1'b1, 1'b1, 1'b0, 1'b0, 18'h00100);
        check("R3 both", 32'(src_ctl), 32'd0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 18'h00200);
        check("R3 ctl", 32'(src_ctl), 32'd1);
        step(1'b0, 1'b0, 1'b1, 1'b0, '0);
        check("R3 hold", 32'(src_ctl), 32'd1);
        step(1'b1, 1'b0, 1'b0, 1'b0, 18'h00300);
        check("R3 cpu", 32'(src_ctl), 32'd0);

        // R4 advance ignored on load
        step(1'b0, 1'b0, 1'b1, 1'b1, '0);
        step(1'b0, 1'b1, 1'b1, 1'b1, 18'h05556);
        check("R4 load+adv", 32'(mem_addr), 32'h05556);

        // R10 back-to-back loads
        step(1'b1, 1'b0, 1'b0, 1'b0, 18'h11111);
        check("R10 b2b", 32'(mem_addr), 32'h11111);
        step(1'b0, 1'b1, 1'b1, 1'b0, 18'h22222);
        check("R10 b2b", 32'(mem_addr), 32'h22222);
        step(1'b1, 1'b0, 1'b0, 1'b0, 18'h33333);
        check("R10 b2b", 32'(mem_addr), 32'h33333);

        // random phase, model check (R2 load/R5 R6 steps/R7 hold)
        for (int i = 0; i < 4000; i++) begin
            logic cpu, ctl, adv, ord;
            logic [AW-1:0] a;
            cpu = ($urandom_range(0, 5) == 0);
            ctl = ($urandom_range(0, 5) == 0);
            adv = ($urandom_range(0, 3) != 0);
            a   = AW'($urandom);
            ord = order_lin;
            if ((cpu || ctl) && $urandom_range(0, 3) == 0) ord = ~order_lin;
            step(cpu, ctl, adv, ord, a);
            check("R2 rand addr", 32'(mem_addr), 32'(exp_addr()));
            check("R3 rand src", 32'(src_ctl), 32'(m_src));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule